// File: doc/BRIEF.md
# Packed Multiply-Add and Rounding Multiply Unit

This unit is a two-stage packed integer multiply datapath working on 128-bit operands. A one-bit opcode selects between two operations. The first is a byte multiply-add. Each byte of operand A is read as unsigned and each byte of operand B as signed. The two products that come from a neighbouring pair of byte lanes are added, and the sum is clamped into a signed 16-bit output lane. The second operation is a fixed-point multiply on signed 16-bit elements. It keeps a rounded, scaled upper part of each 32-bit product, which gives a Q15 multiply with round-to-nearest.

The caller presents both operands, the opcode and a valid strobe in one cycle. In the first stage the partial products are registered: sixteen byte products and eight scaled word products. The second stage forms the pair sums, applies saturation or rounding, selects by opcode and registers the 128-bit result. Every accepted input gives exactly one result two clocks later. A new input can be accepted on every cycle, whatever the opcode.

Top module: `pmac_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` are 0 after that edge.
- R2: `out_valid` is high exactly two rising edges after an edge that samples `in_valid` high, and low in every other cycle.
- R3: With `in_op`=0, output lane k (bits [16k+15:16k], k=0..7) equals A byte 2k (unsigned) times B byte 2k (signed), plus A byte 2k+1 (unsigned) times B byte 2k+1 (signed). Byte j is bits [8j+7:8j].
- R4: In the multiply-add, a pair sum above 32767 yields 0x7FFF. An example is 255×127 twice.
- R5: In the multiply-add, a pair sum below −32768 yields 0x8000. An example is 255×(−128) twice.
- R6: With `in_op`=1, output lane k equals bits [16:1] of ((P >>> 14) + 1). Here P is the full 32-bit signed product of A lane k and B lane k, both 16-bit signed.
- R7: In the rounding multiply, 0x8000×0x8000 gives 0x8000, with no clamp.
- R8: Inputs accepted on consecutive cycles with different opcodes each give their own correct result, in order and on consecutive cycles.
- R9: `out_data` keeps its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| in_op | input | 1 | 0 = byte multiply-add, 1 = rounding word multiply |
| opnd_a | input | 128 | Operand A |
| opnd_b | input | 128 | Operand B |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Registered result |

## Verification
The two operations meet when one opcode's products sit in the first stage while the other opcode's result is being formed in the second stage. The bench provokes this with directed runs of inputs on consecutive cycles with alternating opcodes, and with random stimulus in which both the opcode and the valid strobe change freely. Every output cycle is compared with a reference model of the input that was accepted two edges earlier. A mix-up between stages would therefore show as a wrong lane value or a result in the wrong slot.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    localparam int VEC_W    = 128;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int NBYTE    = VEC_W / BYTE_W;
    localparam int NWORD    = VEC_W / WORD_W;
    localparam int BPROD_W  = 2 * BYTE_W + 1;      // u8 * s8 fits in 17 bits signed
    localparam int PSUM_W   = BPROD_W + 1;         // sum of two byte products
    localparam int WPROD_W  = 2 * WORD_W;          // full signed word product
    localparam int RND_SH   = WORD_W - 2;          // keep the top 18 bits
    localparam int HI_W     = WPROD_W - RND_SH;

    typedef enum logic {
        OP_MADD = 1'b0,
        OP_MULR = 1'b1
    } pmac_op_e;

    typedef struct packed {
        logic                            vld;
        pmac_op_e                        op;
        logic [NBYTE-1:0][BPROD_W-1:0]   bprod;
        logic [NWORD-1:0][HI_W-1:0]      whi;
    } pmac_stage1_t;

    function automatic logic [WORD_W-1:0] sat_word(input logic signed [PSUM_W-1:0] v);
        logic signed [PSUM_W-1:0] hi_lim;
        logic signed [PSUM_W-1:0] lo_lim;
        hi_lim = PSUM_W'(signed'({1'b0, {(WORD_W-1){1'b1}}}));
        lo_lim = PSUM_W'(signed'({1'b1, {(WORD_W-1){1'b0}}}));
        if (v > hi_lim)
            return {1'b0, {(WORD_W-1){1'b1}}};
        else if (v < lo_lim)
            return {1'b1, {(WORD_W-1){1'b0}}};
        else
            return v[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/pmac_byte_mul.sv
module pmac_byte_mul
    import pmac_pkg::*;
(
    input  logic [VEC_W-1:0]                a_vec,
    input  logic [VEC_W-1:0]                b_vec,
    output logic [NBYTE-1:0][BPROD_W-1:0]   prod
);
    for (genvar i = 0; i < NBYTE; i++) begin : g_lane
        logic signed [BPROD_W-1:0] ua;
        logic signed [BPROD_W-1:0] sb;
        assign ua = signed'(BPROD_W'({1'b0, a_vec[i*BYTE_W +: BYTE_W]}));
        assign sb = BPROD_W'(signed'(b_vec[i*BYTE_W +: BYTE_W]));
        assign prod[i] = ua * sb;
    end
endmodule

// File: rtl/pmac_word_mul.sv
module pmac_word_mul
    import pmac_pkg::*;
(
    input  logic [VEC_W-1:0]             a_vec,
    input  logic [VEC_W-1:0]             b_vec,
    output logic [NWORD-1:0][HI_W-1:0]   hi
);
    for (genvar i = 0; i < NWORD; i++) begin : g_lane
        logic signed [WPROD_W-1:0] ax;
        logic signed [WPROD_W-1:0] bx;
        logic signed [WPROD_W-1:0] full;
        assign ax   = WPROD_W'(signed'(a_vec[i*WORD_W +: WORD_W]));
        assign bx   = WPROD_W'(signed'(b_vec[i*WORD_W +: WORD_W]));
        assign full = ax * bx;
        assign hi[i] = HI_W'(full >>> RND_SH);
    end
endmodule

// File: rtl/pmac_combine.sv
module pmac_combine
    import pmac_pkg::*;
(
    input  pmac_stage1_t       s1,
    output logic [VEC_W-1:0]   result
);
    logic [VEC_W-1:0] madd_res;
    logic [VEC_W-1:0] mulr_res;

    for (genvar k = 0; k < NWORD; k++) begin : g_lane
        logic signed [PSUM_W-1:0] psum;
        logic signed [HI_W-1:0]   rnd;
        assign psum = PSUM_W'(signed'(s1.bprod[2*k])) + PSUM_W'(signed'(s1.bprod[2*k+1]));
        assign madd_res[k*WORD_W +: WORD_W] = sat_word(psum);
        assign rnd  = signed'(s1.whi[k]) + HI_W'(1);
        assign mulr_res[k*WORD_W +: WORD_W] = rnd[WORD_W:1];
    end

    always_comb begin
        case (s1.op)
            OP_MULR: result = mulr_res;
            default: result = madd_res;
        endcase
    end
endmodule

// File: rtl/pmac_top.sv
module pmac_top
    import pmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_op,
    input  logic [VEC_W-1:0]   opnd_a,
    input  logic [VEC_W-1:0]   opnd_b,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_data
);
    logic [NBYTE-1:0][BPROD_W-1:0] bprod_d;
    logic [NWORD-1:0][HI_W-1:0]    whi_d;
    pmac_stage1_t                  s1_q;
    logic [VEC_W-1:0]              res_d;

    pmac_byte_mul u_bmul (
        .a_vec (opnd_a),
        .b_vec (opnd_b),
        .prod  (bprod_d)
    );

    pmac_word_mul u_wmul (
        .a_vec (opnd_a),
        .b_vec (opnd_b),
        .hi    (whi_d)
    );

    // Stage 1: register partial products
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_valid;
            if (in_valid) begin
                s1_q.op    <= pmac_op_e'(in_op);
                s1_q.bprod <= bprod_d;
                s1_q.whi   <= whi_d;
            end
        end
    end

    pmac_combine u_comb (
        .s1     (s1_q),
        .result (res_d)
    );

    // Stage 2: register result
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_q.vld;
            if (s1_q.vld)
                out_data <= res_d;
        end
    end
endmodule

// File: rtl/pmac_checker.sv
module pmac_checker
    import pmac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_op,
    input logic [VEC_W-1:0]   opnd_a,
    input logic [VEC_W-1:0]   opnd_b,
    input logic               out_valid,
    input logic [VEC_W-1:0]   out_data
);
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (rst)
            seen <= 2'd0;
        else if (seen != 2'd2)
            seen <= seen + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_valid == 1'b0 && out_data == '0));

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R3
    madd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2 && out_valid && $past(in_op, 2) == 1'b0 && $past(opnd_a, 2) == '0)
        |-> (out_data == '0));

    // R6
    mulr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2 && out_valid && $past(in_op, 2) == 1'b1 && $past(opnd_b, 2) == '0)
        |-> (out_data == '0));

    // R7
    mulr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2 && out_valid && $past(in_op, 2) == 1'b1
         && $past(opnd_a, 2) == {NWORD{16'h8000}} && $past(opnd_b, 2) == {NWORD{16'h8000}})
        |-> (out_data == {NWORD{16'h8000}}));
endmodule

bind pmac_top pmac_checker u_chk (.*);

// File: tb/pmac_top_bench.sv
`timescale 1ns/1ps
module pmac_top_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_op;
    logic [127:0] opnd_a;
    logic [127:0] opnd_b;
    logic         out_valid;
    logic [127:0] out_data;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pmac_top u_pmac_top (.*);

    function automatic logic [127:0] ref_madd(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        for (int k = 0; k < 8; k++) begin
            int p0, p1, s;
            p0 = int'(a[16*k +: 8])   * int'($signed(b[16*k +: 8]));
            p1 = int'(a[16*k+8 +: 8]) * int'($signed(b[16*k+8 +: 8]));
            s  = p0 + p1;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            r[16*k +: 16] = s[15:0];
        end
        return r;
    endfunction

    function automatic logic [127:0] ref_mulr(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        for (int k = 0; k < 8; k++) begin
            int p, t;
            p = int'($signed(a[16*k +: 16])) * int'($signed(b[16*k +: 16]));
            t = ((p >>> 14) + 1) >>> 1;
            r[16*k +: 16] = t[15:0];
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // two-deep expectation pipe
    logic         pv [2];
    logic [127:0] pd [2];
    string        ptag [2];
    logic [127:0] last_data;
    logic         last_op;
    logic         last_v;

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic op, input logic [127:0] a, input logic [127:0] b,
                        input string xtag);
        logic [127:0] e;
        string t;
        // compare output against the input from two edges ago (R2)
        check("R2 valid", {127'd0, out_valid}, {127'd0, pv[1]});
        if (pv[1]) begin
            check(ptag[1], out_data, pd[1]);
            last_data = pd[1];
        end else begin
            check("R9 hold", out_data, last_data);
        end
        pv[1] = pv[0]; pd[1] = pd[0]; ptag[1] = ptag[0];
        e = op ? ref_mulr(a, b) : ref_madd(a, b);
        t = op ? "R6 mulr" : "R3 madd";
        if (v && last_v && (op != last_op)) t = {t, " R8 mixed"};
        t = {t, xtag};
        pv[0] = v; pd[0] = e; ptag[0] = t;
        last_v = v; last_op = op;
        in_valid = v; in_op = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        rst = 1'b1; in_valid = 1'b0; in_op = 1'b0; opnd_a = '0; opnd_b = '0;
        pv[0] = 0; pv[1] = 0; pd[0] = '0; pd[1] = '0; ptag[0] = ""; ptag[1] = "";
        last_data = '0; last_op = 0; last_v = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 data", out_data, 128'd0);
        rst = 1'b0;

        // directed corners
        step(1, 0, {16{8'hFF}}, {16{8'h7F}}, " R4 posclamp");
        step(1, 0, {16{8'hFF}}, {16{8'h80}}, " R5 negclamp");
        step(1, 1, {8{16'h8000}}, {8{16'h8000}}, " R7 wrap");
        step(1, 1, {8{16'h4000}}, {8{16'h4000}}, " half*half");
        step(1, 1, {8{16'h0001}}, {8{16'h4000}}, " round-up");
        step(1, 0, {16{8'h01}}, {16{8'hFF}}, " neg small");
        step(0, 0, '1, '1, " idle");
        step(0, 1, '1, '0, " idle");
        step(0, 0, '0, '1, " idle");
        // alternating back-to-back
        for (int i = 0; i < 12; i++)
            step(1, i[0], rnd128(), rnd128(), " alt");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, 1'($urandom), rnd128(), rnd128(), "");
        end
        // drain
        for (int i = 0; i < 4; i++)
            step(0, 0, rnd128(), rnd128(), " drain");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule